// File: doc/BRIEF.md
# Tagged Read Miss Router

This block keeps track of read misses that a non-blocking cache has sent out to memory. Every accepted read gets a record that holds the short tag of its line request, the word offset inside the line and the identifier of the register or unit that waits for the word. The first read to a line that has no request in flight takes a free tag and starts one external request. Later reads to that same line only add a record and share the request.

A returning line carries its tag back. The block then enters a delivery phase. It walks all records that belong to that tag, from the lowest record slot to the highest, one per cycle. For each record it sends the selected word to the writeback port. After the last one it releases the tag and returns to idle. New reads are held while a delivery runs. A reply whose tag is not in use is dropped and flagged.

The controller has two states. `ST_IDLE` takes requests and replies. `ST_DRAIN` delivers one record per cycle. Transition T_TAKE (`ST_IDLE` to `ST_DRAIN`) fires on a reply with a tag in use. Transition T_MORE (`ST_DRAIN` to `ST_DRAIN`) fires while more than one record of that tag remains. Transition T_LAST (`ST_DRAIN` to `ST_IDLE`) fires on the cycle that delivers the final record.

Top module: `read_miss_router`

## Requirements
- R1: After reset, no record or tag is in use. `rsp_ready` is 1 and `wb_valid` is 0.
- R2: A cycle is an offer when `req_valid` is 1 in `ST_IDLE` and no reply is taken. An offer gets `req_ack` in that same cycle when a record slot is free, and either the line is already pending or a tag is free. The record goes into the lowest free slot.
- R3: When all NREC record slots are in use, an offer gets `req_reject` and no `req_ack` or `mem_req_valid`. This holds even when the line is already pending.
- R4: An acknowledged read to a line with no pending request raises `mem_req_valid` in the same cycle. It carries the lowest free tag on `mem_req_tag` and the line on `mem_req_line`.
- R5: An acknowledged read to a line that already has a pending request does not raise `mem_req_valid`. The read joins that request's tag.
- R6: In `ST_IDLE`, a reply whose `rsp_tag` is in use is taken. From the next cycle on, one `wb_valid` pulse follows for each record of that tag. Each pulse carries the record's `wb_dst` and word `rsp_data[ofs*WORD_W +: WORD_W]`, where word 0 is in the low bits.
- R7: The records of one reply are delivered on consecutive cycles, in ascending record slot index.
- R8: During delivery, `rsp_ready` is 0 and requests get neither ack nor reject. In the cycle after the last delivery the block is idle, and the released tag and slots can be allocated again.
- R9: In `ST_IDLE`, a reply whose tag is not in use raises `rsp_err` in that cycle. It produces no delivery and leaves the block idle.
- R10: In a cycle where a reply is taken, a pending request gets neither ack nor reject, and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read miss offered |
| req_line | input | LINE_W | Line address of the read |
| req_ofs | input | OFS_W | Word offset within the line |
| req_dst | input | DST_W | Destination register or unit id |
| req_ack | output | 1 | Read recorded this cycle |
| req_reject | output | 1 | Read refused, no room |
| mem_req_valid | output | 1 | New line request to memory |
| mem_req_tag | output | TAG_W | Tag given to the new request |
| mem_req_line | output | LINE_W | Line address of the new request |
| rsp_valid | input | 1 | Line reply present |
| rsp_tag | input | TAG_W | Tag carried by the reply |
| rsp_data | input | NWORD*WORD_W | Full line, word 0 in low bits |
| rsp_ready | output | 1 | Reply can be taken this cycle |
| rsp_err | output | 1 | Reply tag not in use, reply dropped |
| wb_valid | output | 1 | Routed word present |
| wb_dst | output | DST_W | Destination of the routed word |
| wb_data | output | WORD_W | Routed word |

## Verification
Replies are tried for a line with a single reader and for a line with three merged readers. In the merged case the slots are not contiguous, which tells ascending-slot order apart from arrival order or a plain count. Tags are reused after release, which shows that the lowest free tag is chosen again and not a stale one. A fully occupied buffer is offered both a new line and a pending line, which tells the record-space limit apart from the tag limit. A request held across a delivery, and a request that coincides with a taken reply, separate the hold-off from the normal acknowledge.

// File: rtl/rtb_pkg.sv
`timescale 1ns/1ps
package rtb_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } rtb_state_e;
endpackage

// File: rtl/rtb_lowest.sv
`timescale 1ns/1ps
module rtb_lowest #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rtb_tag_table.sv
`timescale 1ns/1ps
module rtb_tag_table #(
    parameter int NTAG   = 8,
    parameter int LINE_W = 10,
    parameter int TAG_W  = (NTAG > 1) ? $clog2(NTAG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    input  logic              alloc_en,
    input  logic              free_en,
    input  logic [TAG_W-1:0]  free_tag,
    output logic              hit,
    output logic [TAG_W-1:0]  hit_tag,
    output logic              tag_avail,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic [NTAG-1:0]   busy
);
    logic [LINE_W-1:0] line_q [NTAG];
    logic [NTAG-1:0]   match;

    for (genvar g = 0; g < NTAG; g++) begin : g_cmp
        assign match[g] = busy[g] && (line_q[g] == look_line);
    end

    rtb_lowest #(.N(NTAG), .IW(TAG_W)) u_hit  (.vec(match), .found(hit),       .idx(hit_tag));
    rtb_lowest #(.N(NTAG), .IW(TAG_W)) u_free (.vec(~busy), .found(tag_avail), .idx(alloc_tag));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            for (int i = 0; i < NTAG; i++) line_q[i] <= '0;
        end else begin
            if (alloc_en) begin
                busy[alloc_tag]   <= 1'b1;
                line_q[alloc_tag] <= look_line;
            end
            if (free_en) busy[free_tag] <= 1'b0;
        end
    end

    AST_TAG_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> tag_avail);                                  // R4
    AST_TAG_FREE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> busy[free_tag]);                              // R8
    AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));                                         // R5
endmodule

// File: rtl/rtb_record_store.sv
`timescale 1ns/1ps
module rtb_record_store #(
    parameter int NREC  = 8,
    parameter int TAG_W = 3,
    parameter int OFS_W = 2,
    parameter int DST_W = 5,
    parameter int RI_W  = (NREC > 1) ? $clog2(NREC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [DST_W-1:0] wr_dst,
    input  logic [TAG_W-1:0] sel_tag,
    input  logic             clr_en,
    output logic             slot_avail,
    output logic             pick_found,
    output logic [RI_W-1:0]  pick_idx,
    output logic [OFS_W-1:0] pick_ofs,
    output logic [DST_W-1:0] pick_dst,
    output logic             pick_last
);
    logic [NREC-1:0]  used;
    logic [TAG_W-1:0] tag_q [NREC];
    logic [OFS_W-1:0] ofs_q [NREC];
    logic [DST_W-1:0] dst_q [NREC];
    logic [NREC-1:0]  sel;
    logic [RI_W-1:0]  wr_idx;

    for (genvar g = 0; g < NREC; g++) begin : g_sel
        assign sel[g] = used[g] && (tag_q[g] == sel_tag);
    end

    rtb_lowest #(.N(NREC), .IW(RI_W)) u_slot (.vec(~used), .found(slot_avail), .idx(wr_idx));
    rtb_lowest #(.N(NREC), .IW(RI_W)) u_pick (.vec(sel),   .found(pick_found), .idx(pick_idx));

    assign pick_ofs  = ofs_q[pick_idx];
    assign pick_dst  = dst_q[pick_idx];
    assign pick_last = ($countones(sel) == 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
            for (int i = 0; i < NREC; i++) begin
                tag_q[i] <= '0;
                ofs_q[i] <= '0;
                dst_q[i] <= '0;
            end
        end else begin
            if (wr_en) begin
                used[wr_idx]  <= 1'b1;
                tag_q[wr_idx] <= wr_tag;
                ofs_q[wr_idx] <= wr_ofs;
                dst_q[wr_idx] <= wr_dst;
            end
            if (clr_en) used[pick_idx] <= 1'b0;
        end
    end

    AST_REC_WR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> slot_avail);                                    // R3
    AST_REC_NO_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));                                      // R8
endmodule

// File: rtl/read_miss_router.sv
`timescale 1ns/1ps
module read_miss_router
    import rtb_pkg::*;
#(
    parameter int NREC   = 8,
    parameter int NTAG   = 8,
    parameter int LINE_W = 10,
    parameter int OFS_W  = 2,
    parameter int DST_W  = 5,
    parameter int WORD_W = 16,
    localparam int TAG_W   = (NTAG > 1) ? $clog2(NTAG) : 1,
    localparam int RI_W    = (NREC > 1) ? $clog2(NREC) : 1,
    localparam int NWORD   = 1 << OFS_W,
    localparam int LDATA_W = NWORD * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LINE_W-1:0]  req_line,
    input  logic [OFS_W-1:0]   req_ofs,
    input  logic [DST_W-1:0]   req_dst,
    output logic               req_ack,
    output logic               req_reject,
    output logic               mem_req_valid,
    output logic [TAG_W-1:0]   mem_req_tag,
    output logic [LINE_W-1:0]  mem_req_line,
    input  logic               rsp_valid,
    input  logic [TAG_W-1:0]   rsp_tag,
    input  logic [LDATA_W-1:0] rsp_data,
    output logic               rsp_ready,
    output logic               rsp_err,
    output logic               wb_valid,
    output logic [DST_W-1:0]   wb_dst,
    output logic [WORD_W-1:0]  wb_data
);
    rtb_state_e         state_q, state_d;
    logic [TAG_W-1:0]   cur_tag_q;
    logic [LDATA_W-1:0] line_q;

    logic               hit, tag_avail, slot_avail;
    logic [TAG_W-1:0]   hit_tag, alloc_tag;
    logic [NTAG-1:0]    tag_busy;
    logic               pick_found, pick_last;
    logic [RI_W-1:0]    pick_idx;
    logic [OFS_W-1:0]   pick_ofs;
    logic [DST_W-1:0]   pick_dst;
    logic               rsp_take, offer, clr_en, free_en;

    rtb_tag_table #(.NTAG(NTAG), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .look_line(req_line),
        .alloc_en(mem_req_valid), .free_en(free_en), .free_tag(cur_tag_q),
        .hit(hit), .hit_tag(hit_tag), .tag_avail(tag_avail),
        .alloc_tag(alloc_tag), .busy(tag_busy)
    );

    rtb_record_store #(.NREC(NREC), .TAG_W(TAG_W), .OFS_W(OFS_W),
                       .DST_W(DST_W), .RI_W(RI_W)) u_recs (
        .clk(clk), .rst_n(rst_n), .wr_en(req_ack),
        .wr_tag(hit ? hit_tag : alloc_tag), .wr_ofs(req_ofs), .wr_dst(req_dst),
        .sel_tag(cur_tag_q), .clr_en(clr_en), .slot_avail(slot_avail),
        .pick_found(pick_found), .pick_idx(pick_idx), .pick_ofs(pick_ofs),
        .pick_dst(pick_dst), .pick_last(pick_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_tag_q <= '0;
            line_q    <= '0;
        end else begin
            state_q <= state_d;
            if (rsp_take) begin
                cur_tag_q <= rsp_tag;
                line_q    <= rsp_data;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        rsp_ready     = 1'b0;
        rsp_take      = 1'b0;
        rsp_err       = 1'b0;
        offer         = 1'b0;
        clr_en        = 1'b0;
        free_en       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_ready = 1'b1;
                rsp_take  = rsp_valid && tag_busy[rsp_tag];
                rsp_err   = rsp_valid && !tag_busy[rsp_tag];
                offer     = req_valid && !rsp_take;
                if (rsp_take) state_d = ST_DRAIN;             // T_TAKE
            end
            ST_DRAIN: begin
                clr_en  = pick_found;
                free_en = pick_found && pick_last;
                if (!pick_found || pick_last) state_d = ST_IDLE; // T_LAST, else T_MORE
            end
            default: state_d = ST_IDLE;
        endcase
        req_ack       = offer && slot_avail && (hit || tag_avail);
        req_reject    = offer && !(slot_avail && (hit || tag_avail));
        mem_req_valid = req_ack && !hit;
        mem_req_tag   = alloc_tag;
        mem_req_line  = req_line;
        wb_valid      = clr_en;
        wb_dst        = pick_dst;
        wb_data       = line_q[int'(pick_ofs) * WORD_W +: WORD_W];
    end

    AST_ACK_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ack && req_reject));                                // R2
    AST_DRAIN_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> pick_found);                    // R6
    AST_DRAIN_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid)) |-> (pick_idx > $past(pick_idx))); // R7
    AST_DRAIN_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !req_ack && !req_reject && !rsp_ready);      // R8
    AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !wb_valid);                                   // R9
    AST_TAKE_NO_MEMREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && !rsp_err) |-> !mem_req_valid); // R10
endmodule

// File: tb/tb_read_miss_router.sv
`timescale 1ns/1ps
module tb_read_miss_router;
    localparam int NREC = 8, NTAG = 8, LINE_W = 10, OFS_W = 2, DST_W = 5, WORD_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [LINE_W-1:0] req_line = '0;
    logic [OFS_W-1:0]  req_ofs = '0;
    logic [DST_W-1:0]  req_dst = '0;
    logic req_ack, req_reject, mem_req_valid;
    logic [2:0] mem_req_tag;
    logic [LINE_W-1:0] mem_req_line;
    logic rsp_valid = 1'b0;
    logic [2:0] rsp_tag = '0;
    logic [63:0] rsp_data = '0;
    logic rsp_ready, rsp_err, wb_valid;
    logic [DST_W-1:0] wb_dst;
    logic [WORD_W-1:0] wb_data;

    always #2.5 clk = ~clk;

    read_miss_router dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_ofs(req_ofs), .req_dst(req_dst), .req_ack(req_ack), .req_reject(req_reject),
        .mem_req_valid(mem_req_valid), .mem_req_tag(mem_req_tag), .mem_req_line(mem_req_line),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
        .rsp_err(rsp_err), .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
    );

    int n_checks = 0, n_errors = 0;
    bit done = 1'b0;

    // bench model of records and tags
    bit          mr_v [NREC];
    logic [2:0]  mr_tag [NREC];
    logic [1:0]  mr_ofs [NREC];
    logic [4:0]  mr_dst [NREC];
    bit          mt_b [NTAG];
    logic [9:0]  mt_line [NTAG];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int low_rec();
        for (int i = 0; i < NREC; i++) if (!mr_v[i]) return i;
        return -1;
    endfunction
    function automatic int low_tag();
        for (int i = 0; i < NTAG; i++) if (!mt_b[i]) return i;
        return -1;
    endfunction
    function automatic int hit_of(input logic [9:0] ln);
        for (int i = 0; i < NTAG; i++) if (mt_b[i] && mt_line[i] == ln) return i;
        return -1;
    endfunction
    function automatic logic [63:0] mk_data(input int t);
        logic [63:0] d;
        for (int k = 0; k < 4; k++) d[k*16 +: 16] = 16'(16'hA000 + t * 16 + k);
        return d;
    endfunction

    // exp: 0 new line, 1 merge, 2 reject
    task automatic do_req(input logic [9:0] ln, input logic [1:0] of, input logic [4:0] ds, input int exp);
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_line = ln; req_ofs = of; req_dst = ds;
        #1;
        t = (exp == 1) ? hit_of(ln) : low_tag();
        chk(req_ack == (exp != 2), (exp == 2) ? "R3 ack" : "R2 ack", 64'(req_ack), 64'(exp != 2));
        chk(req_reject == (exp == 2), "R3 reject", 64'(req_reject), 64'(exp == 2));
        chk(mem_req_valid == (exp == 0), (exp == 1) ? "R5 no mem req" : "R4 mem req",
            64'(mem_req_valid), 64'(exp == 0));
        if (exp == 0) begin
            chk(mem_req_tag == 3'(t) && mem_req_line == ln, "R4 tag/line",
                {mem_req_tag, mem_req_line}, {3'(t), ln});
        end
        @(posedge clk);
        if (exp != 2) begin
            int r = low_rec();
            mr_v[r] = 1'b1; mr_tag[r] = 3'(t); mr_ofs[r] = of; mr_dst[r] = ds;
            if (exp == 0) begin mt_b[t] = 1'b1; mt_line[t] = ln; end
        end
        #1 req_valid = 1'b0;
    endtask

    // deliveries after a taken reply, checked against the model
    task automatic drain_expect(input int t);
        logic [63:0] d = mk_data(t);
        for (int i = 0; i < NREC; i++) begin
            if (mr_v[i] && mr_tag[i] == 3'(t)) begin
                @(negedge clk); #1;
                chk(wb_valid && wb_dst == mr_dst[i] && wb_data == d[mr_ofs[i]*16 +: 16],
                    "R6 R7 routed word", {wb_valid, wb_dst, wb_data}, {1'b1, mr_dst[i], d[mr_ofs[i]*16 +: 16]});
                chk(!rsp_ready && !req_ack && !req_reject, "R8 hold during drain",
                    {rsp_ready, req_ack, req_reject}, 3'b000);
                @(posedge clk);
                mr_v[i] = 1'b0;
            end
        end
        mt_b[t] = 1'b0;
        @(negedge clk); #1;
        chk(!wb_valid && rsp_ready, "R8 idle after last", {wb_valid, rsp_ready}, 2'b01);
    endtask

    task automatic do_rsp(input int t, input int exp);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_tag = 3'(t); rsp_data = mk_data(t);
        #1;
        chk(rsp_ready == 1'b1, "R6 ready", 64'(rsp_ready), 64'd1);
        chk(rsp_err == (exp == 3), "R9 err flag", 64'(rsp_err), 64'(exp == 3));
        @(posedge clk);
        #1 rsp_valid = 1'b0;
        if (exp == 3) begin
            @(negedge clk); #1;
            chk(!wb_valid && rsp_ready, "R9 no delivery", {wb_valid, rsp_ready}, 2'b01);
        end else begin
            drain_expect(t);
        end
    endtask

    typedef struct packed {
        logic [1:0] op;   // 0 request, 1 reply
        logic [9:0] line;
        logic [1:0] ofs;
        logic [4:0] dst;
        logic [2:0] tag;
        logic [1:0] exp;  // req: 0 new,1 merge,2 reject; rsp: 0 deliver,3 error
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd0, 10'h010, 2'd1, 5'd3, 3'd0, 2'd0},
        '{2'd0, 10'h020, 2'd2, 5'd4, 3'd0, 2'd0},
        '{2'd0, 10'h010, 2'd3, 5'd5, 3'd0, 2'd1},
        '{2'd0, 10'h010, 2'd0, 5'd6, 3'd0, 2'd1},
        '{2'd1, 10'h000, 2'd0, 5'd0, 3'd0, 2'd0},
        '{2'd1, 10'h000, 2'd0, 5'd0, 3'd5, 2'd3},
        '{2'd0, 10'h030, 2'd1, 5'd7, 3'd0, 2'd0},
        '{2'd0, 10'h010, 2'd2, 5'd8, 3'd0, 2'd0},
        '{2'd1, 10'h000, 2'd0, 5'd0, 3'd1, 2'd0},
        '{2'd1, 10'h000, 2'd0, 5'd0, 3'd0, 2'd0},
        '{2'd1, 10'h000, 2'd0, 5'd0, 3'd2, 2'd0},
        '{2'd1, 10'h000, 2'd0, 5'd0, 3'd2, 2'd3}
    };

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREC; i++) mr_v[i] = 1'b0;
        for (int i = 0; i < NTAG; i++) mt_b[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(rsp_ready && !wb_valid && !req_ack && !req_reject && !mem_req_valid,
            "R1 reset state", {rsp_ready, wb_valid, req_ack, req_reject, mem_req_valid}, 5'b10000);

        for (int v = 0; v < 12; v++) begin
            if (VECS[v].op == 2'd0) do_req(VECS[v].line, VECS[v].ofs, VECS[v].dst, int'(VECS[v].exp));
            else                   do_rsp(int'(VECS[v].tag), int'(VECS[v].exp));
        end

        // fill every record with a distinct line: tags 0..7
        for (int i = 0; i < NREC; i++) do_req(10'(10'h100 + i), 2'(i), 5'(10 + i), 0);
        do_req(10'h1FF, 2'd0, 5'd1, 2);   // R3 new line, full
        do_req(10'h100, 2'd1, 5'd2, 2);   // R3 pending line, full

        // R8: request held across a delivery, then granted with the released tag
        @(negedge clk);
        rsp_valid = 1'b1; rsp_tag = 3'd3; rsp_data = mk_data(3);
        req_valid = 1'b1; req_line = 10'h200; req_ofs = 2'd2; req_dst = 5'd21;
        #1;
        chk(!req_ack && !req_reject && !mem_req_valid, "R10 taken reply blocks request",
            {req_ack, req_reject, mem_req_valid}, 3'b000);
        @(posedge clk);
        #1 rsp_valid = 1'b0;
        drain_expect(3);
        chk(req_ack && mem_req_valid && mem_req_tag == 3'd3 && mem_req_line == 10'h200,
            "R8 released tag reused", {req_ack, mem_req_valid, mem_req_tag}, {1'b1, 1'b1, 3'd3});
        @(posedge clk);
        mr_v[3] = 1'b1; mr_tag[3] = 3'd3; mr_ofs[3] = 2'd2; mr_dst[3] = 5'd21;
        mt_b[3] = 1'b1; mt_line[3] = 10'h200;
        #1 req_valid = 1'b0;

        // drain everything left
        for (int t = 0; t < NTAG; t++) do_rsp(t, 0);
        do_req(10'h3AA, 2'd3, 5'd9, 0);   // R2 empty again, tag 0
        do_rsp(0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule